// File: doc/BRIEF.md
# Standby Conversion Rate Divider

This block paces the conversion starts of a two-channel capacitive sensing front end. A base conversion tick comes in from the surrounding logic, along with a level that says whether the sensor is in standby. The block turns these into one start strobe for each channel. While the sensor is active, every tick starts a conversion on both channels. In standby, a shared divider thins out the ticks for both channels. Channel 2 then passes through a second divider of its own, so its rate is the shared rate divided again.

Two byte-wide registers hold the divider settings. Each register has a 5-bit ratio field and three upper bits that always read as zero. A simple address, write-enable and data port reaches both registers, and read data comes back in the same cycle. The channel 2 divider counts only the ticks that the shared divider lets through, so every channel 2 strobe falls in the same cycle as a channel 1 strobe. Writing either register, or entering standby, starts the divided period over.

Top module: `conv_rate_div`

## Requirements
- R1: Address 0 holds the shared ratio and address 1 holds the channel 2 ratio, each in bits [4:0]. Bits [7:5] of a write are discarded and always read as 0. Addresses 2 and 3 read as 00h, and writes to them change nothing.
- R2: After reset both registers read 01h and both strobes are low.
- R3: Outside standby, every tick produces a strobe on both channels, whatever the ratio fields hold.
- R4: In standby, channel 1 strobes on every N-th tick counted from the restart, where N is the shared ratio field.
- R5: In standby, channel 2 strobes on every (N*M)-th tick counted from the restart, where M is the channel 2 ratio field. Every channel 2 strobe coincides with a channel 1 strobe.
- R6: A ratio field of 0 acts exactly like 1, so conversions never stall.
- R7: The tick count restarts when standby is entered and in any cycle that writes address 0 or 1. In standby, a tick that arrives in a write cycle is not counted and gives no strobe. The first divided strobe then follows a full N (or N*M) ticks later.
- R8: A strobe is a registered pulse that goes high in the cycle after the tick it answers. With no tick there is no strobe. Back-to-back ticks give back-to-back strobes.
- R9: Read data follows the address within the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 2 | Register address |
| reg_wr_en | input | 1 | Write enable for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| standby_i | input | 1 | High while the sensor is in standby |
| tick_i | input | 1 | Base conversion tick, one cycle per tick |
| ch1_start_o | output | 1 | Channel 1 conversion start strobe |
| ch2_start_o | output | 1 | Channel 2 conversion start strobe |

## Verification
The assertions check on every cycle the properties that need no count of earlier ticks. These are: the reserved read bits stay zero, an active tick strobes both channels, a cycle with no tick gives no strobe, a channel 2 strobe always comes with a channel 1 strobe, a ratio of one passes every standby tick, and a register write in standby suppresses the strobe. The exact spacing of divided strobes can only be shown by the bench scenarios, which count ticks against the programmed ratios. The same holds for treating zero as one, for the restart on entering standby, for the handling of reserved and unmapped writes, and for the reset values.

// File: rtl/conv_rate_pkg.sv
// Shared constants for the standby conversion rate divider.
// Assumes byte-wide register access and two sensing channels.
package conv_rate_pkg;
    localparam int DATA_W      = 8;
    localparam int DIV_W       = 5;
    localparam int ADDR_W      = 2;
    localparam int NUM_CH      = 2;
    localparam int FIELD_RESET = 1;
endpackage

// File: rtl/crd_regs.sv
// Divider setting registers.
// One register per channel stage: stage i sits at address i, holds a
// DIV_W-bit ratio field and resets to FIELD_RESET. Upper bits read as zero.
// Assumes a single-cycle write strobe; read data is combinational.
module crd_regs
    import conv_rate_pkg::*;
#(
    parameter int NREG  = NUM_CH,
    parameter int FW    = DIV_W,
    parameter int AW    = ADDR_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [AW-1:0]            addr,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    output logic [NREG-1:0][FW-1:0]  fields,
    output logic                     wr_hit
);
    localparam int PAD_W = DATA_W - FW;

    logic [NREG-1:0] sel;
    logic            unused_hi;

    // Upper write bits are reserved and dropped.
    assign unused_hi = ^wdata[DATA_W-1:FW];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Address decode for this register.
        assign sel[g] = (addr == AW'(g));

        // Field storage with reset value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fields[g] <= FW'(FIELD_RESET);
            end else if (wr_en && sel[g]) begin
                fields[g] <= wdata[FW-1:0];
            end
        end
    end

    // A write counts as a hit only when it lands on a mapped register.
    assign wr_hit = wr_en && (|sel);

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (sel[i]) begin
                rdata = {{PAD_W{1'b0}}, fields[i]};
            end
        end
    end
endmodule

// File: rtl/crd_stage.sv
// One divider stage.
// Counts incoming ticks while run is high and passes every ratio-th tick.
// A ratio of zero acts as one. The count is held at zero while run is low
// and cleared whenever clr is high; a tick in a clear cycle is dropped.
module crd_stage #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         clr,
    input  logic         tick_in,
    input  logic [W-1:0] ratio,
    output logic         pass_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] eff_ratio;
    logic         at_last;
    logic         counting;

    // Zero ratio is promoted to one.
    assign eff_ratio = (ratio == '0) ? W'(1) : ratio;
    assign at_last   = (cnt_q == eff_ratio - W'(1));
    assign counting  = run && !clr && tick_in;
    assign pass_o    = counting && at_last;

    // Tick counter with restart on clear or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || clr) begin
            cnt_q <= '0;
        end else if (counting) begin
            cnt_q <= at_last ? '0 : cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/conv_rate_div.sv
// Standby conversion rate divider, top level.
// A chain of divider stages: stage 0 divides the base tick by the shared
// ratio, stage 1 divides what stage 0 passes by the channel 2 ratio.
// Channel c strobes on the output of stage c while in standby and on every
// tick otherwise. Strobes are registered, one cycle after the tick.
// Assumes tick_i and standby_i are synchronous to clk.
module conv_rate_div
    import conv_rate_pkg::*;
#(
    parameter int RATIO_W = DIV_W,
    parameter int REG_AW  = ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic                reg_wr_en,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                standby_i,
    input  logic                tick_i,
    output logic                ch1_start_o,
    output logic                ch2_start_o
);
    logic [NUM_CH-1:0][RATIO_W-1:0] ratio_fld;
    logic [NUM_CH:0]                chain;
    logic [NUM_CH-1:0]              start_q;
    logic                           wr_hit;
    logic [RATIO_W-1:0]             shared_fld;

    crd_regs #(
        .NREG (NUM_CH),
        .FW   (RATIO_W),
        .AW   (REG_AW)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (reg_addr),
        .wr_en  (reg_wr_en),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .fields (ratio_fld),
        .wr_hit (wr_hit)
    );

    assign chain[0]   = tick_i;
    assign shared_fld = ratio_fld[0];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        crd_stage #(
            .W (RATIO_W)
        ) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (standby_i),
            .clr     (wr_hit),
            .tick_in (chain[c]),
            .ratio   (ratio_fld[c]),
            .pass_o  (chain[c+1])
        );

        // Strobe register: divided in standby, every tick when active.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                start_q[c] <= 1'b0;
            end else begin
                start_q[c] <= standby_i ? chain[c+1] : tick_i;
            end
        end
    end

    assign ch1_start_o = start_q[0];
    assign ch2_start_o = start_q[NUM_CH-1];
endmodule

// File: rtl/crd_checker.sv
// Cycle-level properties of the conversion rate divider, bound to the top.
module crd_checker
    import conv_rate_pkg::*;
#(
    parameter int RATIO_W = DIV_W,
    parameter int REG_AW  = ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic                reg_wr_en,
    input  logic [DATA_W-1:0]   reg_rdata,
    input  logic                standby_i,
    input  logic                tick_i,
    input  logic                ch1_start_o,
    input  logic                ch2_start_o,
    input  logic [RATIO_W-1:0]  shared_fld
);
    logic mapped_wr;
    assign mapped_wr = reg_wr_en && (reg_addr < REG_AW'(NUM_CH));

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:RATIO_W] == '0); // R1
    AST_ACTIVE_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
        (!standby_i && tick_i) |=> (ch1_start_o && ch2_start_o)); // R3
    AST_CH2_WITH_CH1: assert property (@(posedge clk) disable iff (!rst_n)
        ch2_start_o |-> ch1_start_o); // R5
    AST_UNIT_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_i && tick_i && !mapped_wr && shared_fld <= RATIO_W'(1))
        |=> ch1_start_o); // R6
    AST_WR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_i && mapped_wr) |=> (!ch1_start_o && !ch2_start_o)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> (!ch1_start_o && !ch2_start_o)); // R8
endmodule

bind conv_rate_div crd_checker #(
    .RATIO_W (RATIO_W),
    .REG_AW  (REG_AW)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_wr_en   (reg_wr_en),
    .reg_rdata   (reg_rdata),
    .standby_i   (standby_i),
    .tick_i      (tick_i),
    .ch1_start_o (ch1_start_o),
    .ch2_start_o (ch2_start_o),
    .shared_fld  (shared_fld)
);

// File: tb/test_conv_rate_div.sv
`timescale 1ns/1ps
module test_conv_rate_div;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       standby_i = 1'b0;
    logic       tick_i = 1'b0;
    logic       ch1_start_o, ch2_start_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    conv_rate_div i_conv_rate_div (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .standby_i(standby_i),
        .tick_i(tick_i), .ch1_start_o(ch1_start_o), .ch2_start_o(ch2_start_o)
    );

    typedef struct packed {
        logic [7:0] dv;
        logic [7:0] sv;
        logic       sby;
        logic [7:0] nt;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VEC [NVEC] = '{
        '{8'h01, 8'h01, 1'b0, 8'd6},
        '{8'h05, 8'h03, 1'b0, 8'd6},
        '{8'h01, 8'h01, 1'b1, 8'd6},
        '{8'h03, 8'h01, 1'b1, 8'd9},
        '{8'h02, 8'h03, 1'b1, 8'd12},
        '{8'h00, 8'h04, 1'b1, 8'd8},
        '{8'h04, 8'h00, 1'b1, 8'd8},
        '{8'hE3, 8'hA2, 1'b1, 8'd12},
        '{8'h1F, 8'h01, 1'b1, 8'd62}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wr_en = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // One tick, then sample both strobes in the cycle after it.
    task automatic do_tick(output logic s1, output logic s2);
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        s1 = ch1_start_o; s2 = ch2_start_o;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        logic s1, s2;
        int n, m;
        string t1, t2;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset values
        rd(2'd0, d); chk("R2 shared reset", d, 8'h01);
        rd(2'd1, d); chk("R2 sub reset", d, 8'h01);
        chk("R2 strobes idle", {6'b0, ch1_start_o, ch2_start_o}, 8'h00);

        // R1: unmapped addresses
        wr(2'd2, 8'hFF); wr(2'd3, 8'h1F);
        rd(2'd2, d); chk("R1 unmapped read", d, 8'h00);
        rd(2'd3, d); chk("R1 unmapped read", d, 8'h00);
        rd(2'd0, d); chk("R1 unmapped write no effect", d, 8'h01);
        rd(2'd1, d); chk("R1 unmapped write no effect", d, 8'h01);

        // R9: read follows address without a clock edge
        @(negedge clk);
        wr(2'd0, 8'h07);
        @(negedge clk);
        #1; reg_addr = 2'd1; #1; chk("R9 comb read", reg_rdata, 8'h01);
        reg_addr = 2'd0; #1; chk("R9 comb read", reg_rdata, 8'h07);

        // Vector walk
        for (int v = 0; v < NVEC; v++) begin
            standby_i = 1'b0;
            @(negedge clk);
            wr(2'd0, VEC[v].dv);
            wr(2'd1, VEC[v].sv);
            rd(2'd0, d); chk("R1 readback", d, {3'b0, VEC[v].dv[4:0]});
            rd(2'd1, d); chk("R1 readback", d, {3'b0, VEC[v].sv[4:0]});
            n = (VEC[v].dv[4:0] == 0) ? 1 : int'(VEC[v].dv[4:0]);
            m = (VEC[v].sv[4:0] == 0) ? 1 : int'(VEC[v].sv[4:0]);
            if (!VEC[v].sby) begin t1 = "R3"; t2 = "R3"; end
            else if (VEC[v].dv[4:0] == 0 || VEC[v].sv[4:0] == 0) begin t1 = "R6"; t2 = "R6"; end
            else begin t1 = "R4"; t2 = "R5"; end
            standby_i = VEC[v].sby;
            @(negedge clk);
            for (int k = 1; k <= int'(VEC[v].nt); k++) begin
                do_tick(s1, s2);
                chk(t1, {7'b0, s1}, VEC[v].sby ? {7'b0, (k % n) == 0} : 8'h01);
                chk(t2, {7'b0, s2}, VEC[v].sby ? {7'b0, (k % (n * m)) == 0} : 8'h01);
            end
        end

        // R7: write restarts the count; tick in write cycle dropped
        standby_i = 1'b0;
        wr(2'd0, 8'h03); wr(2'd1, 8'h01);
        standby_i = 1'b1;
        @(negedge clk);
        do_tick(s1, s2); chk("R4 before restart", {7'b0, s1}, 8'h00);
        do_tick(s1, s2); chk("R4 before restart", {7'b0, s1}, 8'h00);
        @(negedge clk);
        reg_addr = 2'd0; reg_wr_en = 1'b1; reg_wdata = 8'h03; tick_i = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; tick_i = 1'b0;
        chk("R7 write-cycle tick dropped", {6'b0, ch1_start_o, ch2_start_o}, 8'h00);
        do_tick(s1, s2); chk("R7 after write tick1", {7'b0, s1}, 8'h00);
        do_tick(s1, s2); chk("R7 after write tick2", {7'b0, s1}, 8'h00);
        do_tick(s1, s2); chk("R7 after write tick3", {6'b0, s1, s2}, 8'h03);

        // R7: re-entering standby restarts the count
        do_tick(s1, s2); chk("R7 partial", {7'b0, s1}, 8'h00);
        do_tick(s1, s2); chk("R7 partial", {7'b0, s1}, 8'h00);
        @(negedge clk); standby_i = 1'b0;
        @(negedge clk); standby_i = 1'b1;
        @(negedge clk);
        do_tick(s1, s2); chk("R7 reentry tick1", {7'b0, s1}, 8'h00);
        do_tick(s1, s2); chk("R7 reentry tick2", {7'b0, s1}, 8'h00);
        do_tick(s1, s2); chk("R7 reentry tick3", {7'b0, s1}, 8'h01);

        // R8: back-to-back ticks in active state, then quiet
        standby_i = 1'b0;
        @(negedge clk);
        tick_i = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R8 back-to-back", {6'b0, ch1_start_o, ch2_start_o}, 8'h03);
        end
        tick_i = 1'b0;
        @(negedge clk);
        chk("R8 pulse ends", {6'b0, ch1_start_o, ch2_start_o}, 8'h00);
        @(negedge clk);
        chk("R8 no tick no strobe", {6'b0, ch1_start_o, ch2_start_o}, 8'h00);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule